// File: doc/BRIEF.md
# Receive Packet Status Queue

This block keeps the bookkeeping for frames held in a receive buffer and presents one 16-bit status word describing the oldest frame. The receive MAC marks the start of each frame, pulses once per byte that lands in the buffer, and closes the frame with a 4-bit error class. The host side reads bytes of the oldest frame one at a time and issues commands through a 5-bit code. One code drops the oldest frame. Another code clears the whole receive side. The frame data, its storage and its CRC check live elsewhere. Only the per-frame length, the error class, the completion state and the diagnostic flags are kept here.

The status word packs three fields. Bit 15 is set while the oldest frame is still arriving, and also when nothing is queued. Bits 14..11 carry the error class the frame closed with. Bits 10..0 carry its byte count. The queue accepts at most eight frames. Beyond that, new frames are refused until the host drops one. A host read past the bytes counted so far latches a sticky fault and produces a one-cycle adapter-failure event.

Top module: `rx_status_queue`

## Requirements
- R1: With no frame held, `status` is 16'h8000. While the oldest frame has not been closed, bit 15 of `status` is 1. Once it is closed, bit 15 is 0.
- R2: Bits 14..11 of `status` hold the 4-bit `mac_err` value given at the close of the oldest frame. For example, 4'b1101 is a CRC error and 4'b1000 is an overrun. These bits read 0 while that frame is still open.
- R3: Bits 10..0 of `status` give the byte count of the oldest frame. The count rises by one for each accepted `mac_byte`, and it is visible while the frame is still open.
- R4: `status_overrun` is 1 exactly while eight frames (open or closed) are held. A `mac_start` seen then is refused and adds no entry. The flag drops in the cycle after a discard removes a frame.
- R5: `receiving` goes to 1 in the cycle after an accepted `mac_start`. It goes back to 0 in the cycle after the matching `mac_end`.
- R6: A `host_rd` while no frame is held, or after as many reads of the oldest frame as its byte count, sets `rx_underrun`. That flag stays at 1 until a receive reset or `rst`. Such a read does not advance the read position.
- R7: `adapter_fail` is high for exactly one cycle, in the cycle after the read that first sets `rx_underrun`.
- R8: `cmd_valid` with `cmd_code` = 8 removes the oldest frame if it is closed and restarts the read position at 0. If the oldest frame is still open, or no frame is held, the command has no effect.
- R9: Bytes beyond 1514 in a frame leave the count at 1514. That frame closes with error class 4'b1001, whatever `mac_err` says.
- R10: `cmd_valid` with `cmd_code` = 5 empties the queue and clears `receiving`, `rx_underrun` and `adapter_fail`.
- R11: With `rst` high at a clock edge, the block takes the same empty state as in R10.
- R12: A `mac_start` while a frame is open is ignored. A `mac_byte` or `mac_end` while no frame is open is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mac_start | input | 1 | Receive side begins a frame |
| mac_byte | input | 1 | One byte of the open frame has been stored |
| mac_end | input | 1 | Receive side closes the open frame |
| mac_err | input | 4 | Error class given with `mac_end` |
| host_rd | input | 1 | Host reads one byte of the oldest frame |
| cmd_valid | input | 1 | Host command strobe |
| cmd_code | input | 5 | Command code: 8 discards the oldest frame, 5 resets the receive side |
| status | output | 16 | {incomplete/empty, error class, byte count} of the oldest frame |
| receiving | output | 1 | A frame is being accepted |
| status_overrun | output | 1 | Eight frames held; new frames refused |
| rx_underrun | output | 1 | Sticky flag for a read past the counted bytes |
| adapter_fail | output | 1 | One-cycle event when the underrun flag first sets |

## Verification
Every result is held in a register, so every output reflects a stimulus in the first cycle after the clock edge that samples it. This covers the status fields, the overrun flag, `receiving`, the underrun flag and the failure pulse. No output has a combinational path from an input. The bench drives inputs on the falling edge and compares outputs against a behavioural queue model on the following falling edge. That is half a cycle after the edge that consumed the stimulus. Directed checks read the ports at that same point. The pulse check also looks one cycle later to confirm the pulse has dropped.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int LEN_W  = 11;
    localparam int ERR_W  = 4;
    localparam int STAT_W = 1 + ERR_W + LEN_W;
    localparam int CODE_W = 5;

    localparam logic [LEN_W-1:0]  MAX_FRAME    = 11'd1514;
    localparam logic [ERR_W-1:0]  ERR_OVERSIZE = 4'b1001;
    localparam logic [CODE_W-1:0] OP_RX_RESET  = 5'd5;
    localparam logic [CODE_W-1:0] OP_DISCARD   = 5'd8;

    typedef struct packed {
        logic             done;
        logic [ERR_W-1:0] err;
        logic [LEN_W-1:0] len;
    } rxq_entry_t;

    function automatic logic [STAT_W-1:0] status_word(input logic empty,
                                                      input rxq_entry_t e);
        if (empty)
            return {1'b1, {(STAT_W-1){1'b0}}};
        return {~e.done, e.err, e.len};
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             open_en,
    input  logic             byte_en,
    input  logic             close_en,
    input  logic [ERR_W-1:0] close_err,
    input  logic [PTR_W-1:0] tail_idx,
    input  logic [PTR_W-1:0] head_idx,
    output rxq_entry_t       head_entry
);

    rxq_entry_t slots [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        rxq_entry_t ent_q;
        logic       ovf_q;
        logic       here;
        logic       ovf_n;

        assign here  = (tail_idx == PTR_W'(g));
        assign ovf_n = ovf_q | (byte_en && ent_q.len == MAX_FRAME);

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                ent_q <= '0;
                ovf_q <= 1'b0;
            end else if (here && open_en) begin
                ent_q <= '0;
                ovf_q <= 1'b0;
            end else if (here) begin
                if (byte_en && ent_q.len != MAX_FRAME)
                    ent_q.len <= ent_q.len + 1'b1;
                ovf_q <= ovf_n;
                if (close_en) begin
                    ent_q.done <= 1'b1;
                    ent_q.err  <= ovf_n ? ERR_OVERSIZE : close_err;
                end
            end
        end

        assign slots[g] = ent_q;
    end

    assign head_entry = slots[head_idx];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             mac_start,
    input  logic             mac_end,
    input  logic             discard_req,
    input  logic             head_done,
    output logic             open_en,
    output logic             close_en,
    output logic             pop_en,
    output logic [PTR_W-1:0] tail_idx,
    output logic [PTR_W-1:0] head_idx,
    output logic [CNT_W-1:0] occupancy,
    output logic             receiving,
    output logic             full
);

    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] occ_q;
    logic             recv_q;

    function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (occ_q == CNT_W'(DEPTH));
    assign open_en  = mac_start && !recv_q && !full;
    assign close_en = mac_end && recv_q;
    assign pop_en   = discard_req && (occ_q != '0) && head_done;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ_q  <= '0;
            recv_q <= 1'b0;
        end else begin
            if (open_en)
                recv_q <= 1'b1;
            else if (close_en)
                recv_q <= 1'b0;
            if (close_en)
                wr_ptr <= advance(wr_ptr);
            if (pop_en)
                rd_ptr <= advance(rd_ptr);
            case ({open_en, pop_en})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    assign tail_idx  = wr_ptr;
    assign head_idx  = rd_ptr;
    assign occupancy = occ_q;
    assign receiving = recv_q;

endmodule

// File: rtl/rxq_rdtrack.sv
module rxq_rdtrack
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             host_rd,
    input  logic             pop_en,
    input  logic             empty,
    input  logic [LEN_W-1:0] head_len,
    output logic             rx_underrun,
    output logic             fail_pulse
);

    logic [LEN_W-1:0] rd_pos;
    logic             under_q;
    logic             fail_q;
    logic             rd_bad;

    assign rd_bad = host_rd && (empty || rd_pos >= head_len);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rd_pos  <= '0;
            under_q <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            if (pop_en)
                rd_pos <= '0;
            else if (host_rd && !rd_bad)
                rd_pos <= rd_pos + 1'b1;
            if (rd_bad)
                under_q <= 1'b1;
            fail_q <= rd_bad && !under_q;
        end
    end

    assign rx_underrun = under_q;
    assign fail_pulse  = fail_q;

endmodule

// File: rtl/rx_status_queue.sv
module rx_status_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mac_start,
    input  logic              mac_byte,
    input  logic              mac_end,
    input  logic [3:0]        mac_err,
    input  logic              host_rd,
    input  logic              cmd_valid,
    input  logic [4:0]        cmd_code,
    output logic [15:0]       status,
    output logic              receiving,
    output logic              status_overrun,
    output logic              rx_underrun,
    output logic              adapter_fail
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clear, discard_req;
    logic             open_en, close_en, pop_en;
    logic [PTR_W-1:0] tail_idx, head_idx;
    logic [CNT_W-1:0] occupancy;
    logic             full;
    rxq_entry_t       head_entry;

    assign clear       = cmd_valid && (cmd_code == OP_RX_RESET);
    assign discard_req = cmd_valid && (cmd_code == OP_DISCARD);

    rxq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .clear       (clear),
        .mac_start   (mac_start),
        .mac_end     (mac_end),
        .discard_req (discard_req),
        .head_done   (head_entry.done),
        .open_en     (open_en),
        .close_en    (close_en),
        .pop_en      (pop_en),
        .tail_idx    (tail_idx),
        .head_idx    (head_idx),
        .occupancy   (occupancy),
        .receiving   (receiving),
        .full        (full)
    );

    rxq_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .open_en    (open_en),
        .byte_en    (mac_byte && receiving),
        .close_en   (close_en),
        .close_err  (mac_err),
        .tail_idx   (tail_idx),
        .head_idx   (head_idx),
        .head_entry (head_entry)
    );

    rxq_rdtrack u_rd (
        .clk         (clk),
        .rst         (rst),
        .clear       (clear),
        .host_rd     (host_rd),
        .pop_en      (pop_en),
        .empty       (occupancy == '0),
        .head_len    (head_entry.len),
        .rx_underrun (rx_underrun),
        .fail_pulse  (adapter_fail)
    );

    assign status         = status_word(occupancy == '0, head_entry);
    assign status_overrun = full;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [15:0]      status,
    input logic             receiving,
    input logic             status_overrun,
    input logic             rx_underrun,
    input logic             adapter_fail,
    input logic             mac_start,
    input logic             mac_end,
    input logic             cmd_valid,
    input logic [4:0]       cmd_code,
    input logic [CNT_W-1:0] occ
);

    logic rx_reset_cmd;
    assign rx_reset_cmd = cmd_valid && (cmd_code == 5'd5);

    assert_empty_word_R1: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> (status == 16'h8000));

    assert_len_cap_R9: assert property (@(posedge clk) disable iff (rst)
        status[10:0] <= 11'd1514);

    assert_refuse_full_R4: assert property (@(posedge clk) disable iff (rst)
        (status_overrun && mac_start && !cmd_valid) |=> (status_overrun && $stable(occ)));

    assert_end_stops_R5: assert property (@(posedge clk) disable iff (rst)
        (receiving && mac_end && !rx_reset_cmd) |=> !receiving);

    assert_underrun_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_underrun && !rx_reset_cmd) |=> rx_underrun);

    assert_fail_with_flag_R7: assert property (@(posedge clk) disable iff (rst)
        adapter_fail |-> rx_underrun);

    assert_fail_single_R7: assert property (@(posedge clk) disable iff (rst)
        adapter_fail |=> !adapter_fail);

    assert_rx_reset_R10: assert property (@(posedge clk) disable iff (rst)
        rx_reset_cmd |=> (occ == '0 && !rx_underrun && !receiving && !adapter_fail));

endmodule

bind rx_status_queue rxq_checker #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .status         (status),
    .receiving      (receiving),
    .status_overrun (status_overrun),
    .rx_underrun    (rx_underrun),
    .adapter_fail   (adapter_fail),
    .mac_start      (mac_start),
    .mac_end        (mac_end),
    .cmd_valid      (cmd_valid),
    .cmd_code       (cmd_code),
    .occ            (occupancy)
);

// File: tb/rx_status_queue_tb.sv
module rx_status_queue_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mac_start = 1'b0, mac_byte = 1'b0, mac_end = 1'b0;
    logic [3:0]  mac_err = 4'd0;
    logic        host_rd = 1'b0, cmd_valid = 1'b0;
    logic [4:0]  cmd_code = 5'd0;
    logic [15:0] status;
    logic        receiving, status_overrun, rx_underrun, adapter_fail;

    int checks = 0;
    int errors = 0;
    bit armed  = 1'b0;
    bit ended  = 1'b0;

    always #2 clk = ~clk;

    rx_status_queue u_dut (
        .clk            (clk),
        .rst            (rst),
        .mac_start      (mac_start),
        .mac_byte       (mac_byte),
        .mac_end        (mac_end),
        .mac_err        (mac_err),
        .host_rd        (host_rd),
        .cmd_valid      (cmd_valid),
        .cmd_code       (cmd_code),
        .status         (status),
        .receiving      (receiving),
        .status_overrun (status_overrun),
        .rx_underrun    (rx_underrun),
        .adapter_fail   (adapter_fail)
    );

    // Behavioural reference: one queue element per held frame
    int q_len[$];
    int q_err[$];
    bit q_done[$];
    bit q_ovf[$];
    bit m_recv = 0, m_under = 0, m_fail = 0;
    int m_rd = 0;

    always @(posedge clk) begin
        int  sz, hlen;
        bit  orecv, hdone, bad;
        if (rst || (cmd_valid && cmd_code == 5'd5)) begin
            q_len.delete(); q_err.delete(); q_done.delete(); q_ovf.delete();
            m_recv = 0; m_under = 0; m_fail = 0; m_rd = 0;
        end else begin
            sz    = q_len.size();
            orecv = m_recv;
            hlen  = (sz > 0) ? q_len[0] : 0;
            hdone = (sz > 0) ? q_done[0] : 1'b0;
            m_fail = 0;
            if (host_rd) begin
                bad = (sz == 0) || (m_rd >= hlen);
                if (bad) begin
                    if (!m_under) m_fail = 1;
                    m_under = 1;
                end else m_rd++;
            end
            if (orecv && mac_byte) begin
                if (q_len[sz-1] == 1514) q_ovf[sz-1] = 1;
                else q_len[sz-1]++;
            end
            if (orecv && mac_end) begin
                q_done[sz-1] = 1;
                q_err[sz-1]  = q_ovf[sz-1] ? 9 : int'(mac_err);
                m_recv = 0;
            end
            if (!orecv && mac_start && sz < 8) begin
                q_len.push_back(0); q_err.push_back(0);
                q_done.push_back(0); q_ovf.push_back(0);
                m_recv = 1;
            end
            if (cmd_valid && cmd_code == 5'd8 && sz > 0 && hdone) begin
                void'(q_len.pop_front()); void'(q_err.pop_front());
                void'(q_done.pop_front()); void'(q_ovf.pop_front());
                m_rd = 0;
            end
        end
    end

    function automatic logic [15:0] model_status();
        logic [3:0]  e;
        logic [10:0] l;
        if (q_len.size() == 0) return 16'h8000;
        e = q_done[0] ? q_err[0][3:0] : 4'd0;
        l = q_len[0][10:0];
        return {~q_done[0], e, l};
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !ended) begin
            chk("R1/R2/R3 model status", status, model_status());
            chk("R5 model receiving", 16'(receiving), 16'(m_recv));
            chk("R4 model overrun", 16'(status_overrun), 16'(q_len.size() == 8));
            chk("R6 model underrun", 16'(rx_underrun), 16'(m_under));
            chk("R7 model fail", 16'(adapter_fail), 16'(m_fail));
        end
    end

    task automatic cyc();
        @(negedge clk);
        mac_start = 0; mac_byte = 0; mac_end = 0; host_rd = 0; cmd_valid = 0;
    endtask

    task automatic start_frame();
        mac_start = 1; cyc();
    endtask

    task automatic bytes(int n);
        for (int i = 0; i < n; i++) begin mac_byte = 1; cyc(); end
    endtask

    task automatic close_frame(logic [3:0] e);
        mac_end = 1; mac_err = e; cyc();
    endtask

    task automatic frame(int n, logic [3:0] e);
        start_frame(); bytes(n); close_frame(e);
    endtask

    task automatic command(logic [4:0] c);
        cmd_valid = 1; cmd_code = c; cyc();
    endtask

    task automatic reads(int n);
        for (int i = 0; i < n; i++) begin host_rd = 1; cyc(); end
    endtask

    task automatic report();
        ended = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        armed = 1;
        chk("R11 reset status", status, 16'h8000);
        chk("R11 reset receiving", 16'(receiving), 16'h0);

        // R12: byte and end with no open frame are ignored
        bytes(2); close_frame(4'hD);
        chk("R12 stray byte/end", status, 16'h8000);

        // R3/R5/R1: open frame visible as it grows
        start_frame();
        chk("R5 receiving after start", 16'(receiving), 16'h1);
        bytes(3);
        chk("R3 in-progress count", status, 16'h8003);
        mac_start = 1; cyc();   // R12: start while open ignored
        bytes(2);
        close_frame(4'h0);
        chk("R5 receiving dropped", 16'(receiving), 16'h0);
        chk("R1 closed head", status, 16'h0005);

        // R6/R7: reading past the count
        reads(5);
        chk("R6 no underrun yet", 16'(rx_underrun), 16'h0);
        reads(1);
        chk("R6 underrun set", 16'(rx_underrun), 16'h1);
        chk("R7 fail pulse", 16'(adapter_fail), 16'h1);
        cyc();
        chk("R7 fail single", 16'(adapter_fail), 16'h0);
        chk("R6 sticky", 16'(rx_underrun), 16'h1);

        // R10: receive reset
        command(5'd5);
        chk("R10 queue emptied", status, 16'h8000);
        chk("R10 underrun cleared", 16'(rx_underrun), 16'h0);

        // R2: CRC class, then R8 discard
        frame(4, 4'b1101);
        chk("R2 crc class", status, 16'h6804);
        command(5'd8);
        chk("R8 discard head", status, 16'h8000);
        command(5'd8);
        chk("R8 discard empty", status, 16'h8000);

        // R8: discard refused on open head
        start_frame(); bytes(2);
        command(5'd8);
        chk("R8 open head kept", status, 16'h8002);
        close_frame(4'b1000);
        chk("R2 overrun class", status, 16'h4002);

        // R4: fill to eight, refuse ninth, release on discard
        for (int k = 0; k < 7; k++) frame(2, 4'h0);
        chk("R4 overrun at eight", 16'(status_overrun), 16'h1);
        start_frame();
        chk("R4 ninth refused", 16'(receiving), 16'h0);
        command(5'd8);
        chk("R4 overrun cleared", 16'(status_overrun), 16'h0);
        chk("R8 next head", status, 16'h0002);

        // R9: oversize frame
        command(5'd5);
        frame(1520, 4'h0);
        chk("R9 oversize word", status, 16'h4DEA);

        // R11: global reset mid-frame
        start_frame(); bytes(3);
        rst = 1; cyc(); rst = 0;
        chk("R11 reset clears", status, 16'h8000);
        chk("R11 reset receiving", 16'(receiving), 16'h0);

        // R6: read on empty
        reads(1);
        chk("R6 empty read", 16'(rx_underrun), 16'h1);
        cyc();
        report();
    end

endmodule